// File: doc/BRIEF.md
# Status-coded I2C bus master

This block is a byte-at-a-time I2C master that a host sequencer steers through four small registers: control, status, data and own-address. Every bus action the engine completes (a START, a repeated START, an address byte, a data byte, a lost arbitration) ends with the engine frozen, an interrupt flag raised and a fixed hexadecimal code loaded into the status register. The engine stays frozen until the host clears the flag. Clearing the flag takes a control write made while a separate clear-enable input is high.

The host reads the code and loads the data register with the next byte. It then clears the flag, and in the same control write it may request a STOP, a repeated START, or a STOP followed by a fresh START. SDA and SCL are open-drain: the block pulls a line low by raising its output enable and reads the line back through an input. A three-bit rate field sets the SCL period. When the block loses arbitration in an address byte and acknowledge is enabled, it keeps listening as a slave. If the address on the bus turns out to be its own, it acknowledges that address within the same nine-clock byte.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset the interrupt output is low, both output enables are low, the control register reads 00h, the status register reads F8h and the bus counts as free.
- R2: The interrupt flag (control bit 4) is cleared only by a write to the control register (address 0) that carries 0 in bit 4 while the clear-enable input is high. The same write with clear-enable low leaves the flag and the interrupt output set. The host can never set the flag.
- R3: While the flag is set, the interrupt output is high and neither SCL nor SDA changes. The engine does not move until the flag is cleared.
- R4: When enable (bit 7) and start (bit 6) are set and the flag is clear, the block waits until the bus is free and then issues a START. It then holds SCL low, loads status 08h, raises the flag and clears the start bit. The bus counts as busy from any START to the next STOP. When a host control write lands in the same cycle as this completion, the flag ends set and the start bit ends clear.
- R5: When the flag is cleared after a START or a repeated START (start and stop bits both 0), the data register is sent MSB first as the address byte. SDA is released for the ninth clock, and the block loads 18h if SDA was low on that clock or 20h if it was high.
- R6: Any later byte sent the same way loads 28h on an acknowledge or 30h on no acknowledge.
- R7: Clearing the flag with stop (bit 5) set produces a STOP with no interrupt. The stop bit clears itself when a STOP is seen on the bus, and both lines are released.
- R8: Clearing the flag with only start set produces a repeated START. The block then loads status 10h and clears the start bit.
- R9: Clearing the flag with start and stop both set produces a STOP, then a new START once the bus is free, ending with status 08h.
- R10: If the block samples SDA low while SCL is high during a bit in which it released SDA, it has lost arbitration. Unless R11 applies, it releases both lines at once, loads 38h and raises the flag.
- R11: If acknowledge-enable (bit 3) is set and arbitration is lost in an address byte, the block follows the external SCL. It takes in the rest of the byte and pulls SDA low on the ninth clock in either of two cases: bits 7..1 match own-address bits 7..1 with bit 0 = 0 (status 68h), or the byte is 00h and own-address bit 0 is 1 (status 78h). It raises the flag after the ninth clock and copies the byte into the data register. Any other address gives 38h with no acknowledge.
- R12: The SCL period inside a byte is 4·QBASE·2^rate system clocks, where rate is control bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 control, 2 data, 3 own address (1 is read-only status) |
| wr_data | input | 8 | Write data |
| clr_en | input | 1 | Must be high for a control write to clear the interrupt flag |
| rd_addr | input | 2 | Read select, same map as writes, 1 = status |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request, high while the flag is set |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pulls SCL low when high |
| sda_oe | output | 1 | Pulls SDA low when high |

## Verification
The engine's own writes to the control register, which set the flag and clear the start bit when a START completes, can fall in the same cycle as a host control write. The bench provokes this by rewriting control every cycle during a START request, with start set, flag bit 0 and clear-enable high, and stopping only once the interrupt appears. It judges the result by reading back a set flag, a cleared start bit and status 08h. The bench's other master and slave models also force arbitration loss at a known bit, drive the remaining address bits by hand and check that the block acknowledges its own address on the ninth clock.

// File: rtl/i2c_seq_master.sv
module i2c_seq_master #(
  parameter int QBASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       clr_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int QMAX = QBASE << 7;
  localparam int QW   = $clog2(QMAX) + 1;

  typedef enum logic [2:0] {S_IDLE, S_GSTA, S_WAIT, S_XFER, S_GRS, S_GSTO, S_SLV} st_t;

  st_t st;
  logic [QW-1:0] qcnt, qlim;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh, dat_q, own_q, status_q;
  logic en_q, sta_q, stop_q, flag_q, aa_q, is_addr, gcm, scl_d, sda_d, busy;
  logic [2:0] rate_q;

  wire run       = (st == S_GSTA) || (st == S_XFER) || (st == S_GRS) || (st == S_GSTO);
  wire tick      = run && (qcnt == qlim);
  wire start_det = scl_in && scl_d && sda_d && !sda_in;
  wire stop_det  = scl_in && scl_d && !sda_d && sda_in;
  wire scl_rise  = scl_in && !scl_d;
  wire scl_fall  = !scl_in && scl_d;
  wire own_hit   = (sh[7:1] == own_q[7:1]) && !sh[0];
  wire gc_hit    = (sh == 8'h00) && own_q[0];

  assign qlim = QW'(QBASE << rate_q) - 1'b1;
  assign irq  = flag_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {en_q, sta_q, stop_q, flag_q, aa_q, rate_q};
      2'd1:    rd_data = status_q;
      2'd2:    rd_data = dat_q;
      default: rd_data = own_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qcnt <= '0; ph <= 2'd0; bitn <= 4'd0;
      sh <= 8'h00; dat_q <= 8'h00; own_q <= 8'h00; status_q <= 8'hF8;
      en_q <= 1'b0; sta_q <= 1'b0; stop_q <= 1'b0; flag_q <= 1'b0; aa_q <= 1'b0;
      rate_q <= 3'd0; is_addr <= 1'b0; gcm <= 1'b0;
      scl_d <= 1'b1; sda_d <= 1'b1; busy <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (start_det) busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;

      qcnt <= (!run || tick) ? '0 : qcnt + 1'b1;
      if (!run) ph <= 2'd0;
      else if (tick) ph <= ph + 2'd1;

      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            {en_q, sta_q, stop_q} <= wr_data[7:5];
            aa_q   <= wr_data[3];
            rate_q <= wr_data[2:0];
            if (clr_en && !wr_data[4]) flag_q <= 1'b0;
          end
          2'd2: dat_q <= wr_data;
          2'd3: own_q <= wr_data;
          default: ;
        endcase
      end
      if (stop_det) stop_q <= 1'b0;

      case (st)
        S_IDLE: if (en_q && sta_q && !flag_q && !busy) st <= S_GSTA;

        S_GSTA: if (tick) begin
          if (ph == 2'd1) sda_oe <= 1'b1;
          if (ph == 2'd3) begin
            scl_oe <= 1'b1; st <= S_WAIT; status_q <= 8'h08;
            flag_q <= 1'b1; sta_q <= 1'b0; is_addr <= 1'b1;
          end
        end

        S_WAIT: if (!flag_q) begin
          bitn <= 4'd0;
          if (stop_q) st <= S_GSTO;
          else if (sta_q) st <= S_GRS;
          else begin sh <= dat_q; st <= S_XFER; end
        end

        S_XFER: if (tick) begin
          case (ph)
            2'd0: sda_oe <= (bitn < 4'd8) && !sh[7];
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              sh <= {sh[6:0], sda_in};
              if (bitn < 4'd8 && !sda_oe && !sda_in) begin
                scl_oe  <= 1'b0;
                is_addr <= 1'b0;
                if (is_addr && aa_q) begin
                  st <= S_SLV; bitn <= bitn + 4'd1;
                end else begin
                  st <= S_IDLE; status_q <= 8'h38; flag_q <= 1'b1;
                end
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn == 4'd8) begin
                st <= S_WAIT; flag_q <= 1'b1; is_addr <= 1'b0;
                if (is_addr) status_q <= sh[0] ? 8'h20 : 8'h18;
                else         status_q <= sh[0] ? 8'h30 : 8'h28;
              end else bitn <= bitn + 4'd1;
            end
          endcase
        end

        S_GRS: if (tick) begin
          case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1; st <= S_WAIT; status_q <= 8'h10;
              flag_q <= 1'b1; sta_q <= 1'b0; is_addr <= 1'b1;
            end
          endcase
        end

        S_GSTO: if (tick) begin
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: st <= S_IDLE;
          endcase
        end

        S_SLV: begin
          if (scl_rise && bitn < 4'd8) begin
            sh <= {sh[6:0], sda_in}; bitn <= bitn + 4'd1;
          end else if (scl_fall && bitn == 4'd8) begin
            if (aa_q && (own_hit || gc_hit)) begin
              sda_oe <= 1'b1; gcm <= gc_hit; bitn <= 4'd9;
            end else begin
              st <= S_IDLE; status_q <= 8'h38; flag_q <= 1'b1;
            end
          end else if (scl_fall && bitn == 4'd9) begin
            sda_oe <= 1'b0; dat_q <= sh; flag_q <= 1'b1; st <= S_IDLE;
            status_q <= gcm ? 8'h78 : 8'h68;
          end
        end

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_master_chk.sv
module i2c_seq_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       clr_en,
  input logic [7:0] status,
  input logic       stop_bit,
  input logic       stop_det
);
  a_r3_frozen_lines: assert property (@(posedge clk) disable iff (!rst_n)
    irq && $past(irq) |-> $stable(scl_oe) && $stable(sda_oe));

  a_r2_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && wr_addr == 2'd0 && clr_en && !wr_data[4]));

  a_r4_code_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $rose(irq));

  a_r10_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && status == 8'h38 |-> !scl_oe && !sda_oe);

  a_r5_byte_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) && (status == 8'h18 || status == 8'h20) |-> scl_oe);

  a_r7_stop_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_bit) |-> $past(stop_det) || $past(wr_en && wr_addr == 2'd0));
endmodule

bind i2c_seq_master i2c_seq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clr_en(clr_en),
  .status(status_q), .stop_bit(stop_q), .stop_det(stop_det)
);

// File: tb/i2c_seq_master_bench.sv
module i2c_seq_master_bench;
  localparam int QB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, clr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq, scl_oe, sda_oe, scl_bus, sda_bus;
  logic ext_scl = 1'b0, ext_man = 1'b0, ext_arb = 1'b0, slv_low = 1'b0;
  logic arb_on = 1'b0, slv_ack = 1'b0;
  logic [7:0] comp = 8'h00, rxb = 8'h00, got = 8'h00;
  logic sc_d = 1'b1, sd_d = 1'b1;
  int fc = 0, rc = 0, cyc = 0, last_rise = 0, per = 0;
  int total = 0, bad = 0;

  assign scl_bus = !(scl_oe || ext_scl);
  assign sda_bus = !(sda_oe || ext_man || ext_arb || slv_low);

  i2c_seq_master u_i2c_seq_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_en(clr_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    sc_d <= scl_bus;
    sd_d <= sda_bus;
    if (scl_bus && sc_d && sd_d && !sda_bus) begin
      fc <= 0; rc <= 0;
    end else begin
      if (!scl_bus && sc_d) begin
        ext_arb <= (fc < 8) ? (arb_on && !comp[3'(7 - fc)]) : 1'b0;
        slv_low <= (fc == 8) && slv_ack;
        fc <= (fc == 8) ? 0 : fc + 1;
      end
      if (scl_bus && !sc_d) begin
        per <= cyc - last_rise;
        last_rise <= cyc;
        if (rc < 8) begin
          rxb <= {rxb[6:0], sda_bus};
          if (rc == 7) got <= {rxb[6:0], sda_bus};
          rc <= rc + 1;
        end else rc <= 0;
      end
    end
  end

  function automatic logic [7:0] cw(bit sta, bit sto, bit aa, logic [2:0] r);
    return {1'b1, sta, sto, 1'b0, aa, r};
  endfunction
  function automatic logic [7:0] exp_addr(bit a); return a ? 8'h18 : 8'h20; endfunction
  function automatic logic [7:0] exp_data(bit a); return a ? 8'h28 : 8'h30; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic ce);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; clr_en = ce;
    @(negedge clk); wr_en = 1'b0; clr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 30000) begin @(negedge clk); n++; end
    chk({tag, " irq raised"}, irq, 1);
  endtask

  task automatic wait_stop(input string tag);
    logic [7:0] c;
    int n = 0;
    rd(2'd0, c);
    while (c[5] && n < 30000) begin rd(2'd0, c); n++; end
    chk({tag, " stop bit self-cleared"}, c[5], 0);
    repeat (4) @(negedge clk);
    chk({tag, " no irq, lines free"}, {irq, scl_bus, sda_bus}, 3'b011);
  endtask

  task automatic manual_bit(input logic b);
    @(negedge clk); ext_scl = 1'b1;
    repeat (8) @(negedge clk); ext_man = !b;
    repeat (8) @(negedge clk); ext_scl = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic ext_stop();
    @(negedge clk); ext_man = 1'b1; arb_on = 1'b0;
    ext_scl = 1'b1; repeat (8) @(negedge clk);
    ext_scl = 1'b0; repeat (8) @(negedge clk);
    ext_man = 1'b0; repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 irq/oe", {irq, scl_oe, sda_oe}, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'hF8);

    // R4 wait for a busy bus, plus host write colliding with START completion
    @(negedge clk); ext_man = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = cw(1, 0, 0, 3'd0); clr_en = 1'b1;
    repeat (100) @(negedge clk);
    chk("R4 held while bus busy", {scl_oe, sda_oe, irq}, 0);
    ext_man = 1'b0;
    do @(negedge clk); while (!irq && cyc < 20000);
    wr_en = 1'b0; clr_en = 1'b0;
    rd(2'd1, v); chk("R4 status after START", v, 8'h08);
    rd(2'd0, v); chk("R4 flag set, start cleared", {v[6], v[4]}, 2'b01);

    // R2/R3 gated clear
    slv_ack = 1'b1;
    wr(2'd2, 8'h50, 0);
    wr(2'd0, cw(0, 0, 0, 3'd0), 0);
    repeat (40) @(negedge clk);
    chk("R2 flag kept without clear-enable", irq, 1);
    chk("R3 lines frozen", {scl_oe, sda_oe, fc}, {1'b1, 1'b1, 32'd1});
    wr(2'd0, cw(0, 0, 0, 3'd0), 1);
    wait_irq("R5");
    rd(2'd1, v); chk("R5 address acked", v, 8'h18);
    chk("R5 address on bus", got, 8'h50);

    // R8 repeated START, then R9 STOP-then-START
    wr(2'd0, cw(1, 0, 0, 3'd0), 1);
    wait_irq("R8");
    rd(2'd1, v); chk("R8 status", v, 8'h10);
    rd(2'd0, v); chk("R8 start cleared", v[6], 0);
    wr(2'd2, 8'h52, 0);
    wr(2'd0, cw(0, 0, 0, 3'd0), 1);
    wait_irq("R5 after RS");
    rd(2'd1, v); chk("R5 address after repeated START", v, 8'h18);
    wr(2'd0, cw(1, 1, 0, 3'd0), 1);
    wait_irq("R9");
    rd(2'd1, v); chk("R9 status", v, 8'h08);
    rd(2'd0, v); chk("R9 stop and start bits cleared", v[6:5], 2'b00);
    wr(2'd0, cw(0, 1, 0, 3'd0), 1);
    wait_stop("R7");

    // random transfers: R5 R6 R7 R12
    for (int k = 0; k < 16; k++) begin
      logic [2:0] r;
      logic [7:0] a, d;
      bit aka, akd;
      r = 3'($urandom % 3);
      a = 8'($urandom) & 8'hFE;
      d = 8'($urandom);
      aka = ($urandom % 4) != 0;
      akd = ($urandom % 2) != 0;
      wr(2'd0, cw(1, 0, 0, r), 0);
      wait_irq("R4 random");
      rd(2'd1, v); chk("R4 random START", v, 8'h08);
      slv_ack = aka;
      wr(2'd2, a, 0);
      wr(2'd0, cw(0, 0, 0, r), 1);
      wait_irq("R5 random");
      rd(2'd1, v); chk("R5 random address code", v, exp_addr(aka));
      chk("R5 random address bits", got, a);
      chk("R12 SCL period", per, 4 * (QB << r));
      if (aka) begin
        slv_ack = akd;
        wr(2'd2, d, 0);
        wr(2'd0, cw(0, 0, 0, r), 1);
        wait_irq("R6 random");
        rd(2'd1, v); chk("R6 random data code", v, exp_data(akd));
        chk("R6 random data bits", got, d);
      end
      wr(2'd0, cw(0, 1, 0, r), 1);
      wait_stop("R7 random");
    end

    // R10 arbitration loss without slave fallback
    slv_ack = 1'b0; comp = 8'h84;
    wr(2'd3, 8'h84, 0);
    wr(2'd0, cw(1, 0, 0, 3'd0), 0);
    wait_irq("R10 start");
    arb_on = 1'b1;
    wr(2'd2, 8'hA4, 0);
    wr(2'd0, cw(0, 0, 0, 3'd0), 1);
    wait_irq("R10");
    rd(2'd1, v); chk("R10 status", v, 8'h38);
    chk("R10 lines released", {scl_oe, sda_oe}, 2'b00);
    ext_stop();
    wr(2'd0, cw(0, 0, 0, 3'd0), 1);

    // R11 arbitration loss with own-address acknowledge
    wr(2'd0, cw(1, 0, 1, 3'd0), 0);
    wait_irq("R11 start");
    arb_on = 1'b1;
    wr(2'd2, 8'hA4, 0);
    wr(2'd0, cw(0, 0, 1, 3'd0), 1);
    while (rc < 3 && cyc < 150000) @(negedge clk);
    repeat (64) @(negedge clk);
    chk("R11 slave mode, lines released, no irq", {irq, scl_oe, sda_oe}, 0);
    arb_on = 1'b0;
    for (int i = 3; i < 8; i++) manual_bit(comp[7 - i]);
    @(negedge clk); ext_scl = 1'b1; ext_man = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 ack driven on ninth clock", {sda_oe, sda_bus, irq}, 3'b100);
    ext_scl = 1'b0; repeat (16) @(negedge clk);
    ext_scl = 1'b1; repeat (8) @(negedge clk);
    chk("R11 irq after ninth clock, SDA released", {irq, sda_oe}, 2'b10);
    rd(2'd1, v); chk("R11 status", v, 8'h68);
    rd(2'd2, v); chk("R11 received byte", v, 8'h84);
    ext_scl = 1'b0; repeat (8) @(negedge clk);
    ext_stop();
    wr(2'd0, cw(0, 0, 0, 3'd0), 1);
    chk("R2 clear with enable", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule